// File: doc/BRIEF.md
# Data EEPROM Programming Controller

This block sits between a CPU register port and a small byte-wide nonvolatile data array. Software reaches it through one 8-bit control/status byte and through a byte-wide array port. A write to the array either programs a single byte or, in row mode, loads a latch in an eight-byte row buffer. Each programming operation takes a fixed, parameterised number of clock cycles, and a busy flag stays high for that whole time.

In row mode the controller captures the row address from the first buffered write. Later writes only choose a byte lane within that row. A start request commits the buffered lanes in one timed operation. Lanes that were not loaded are written with a fixed fill pattern. While an operation runs, control writes are dropped and array accesses are aborted. Standby turns the array off: writes to it do nothing and reads return zero.

The array itself is modelled as registers that reset to the erased pattern. The programming time is given in clock cycles.

Top module: `ee_prog_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 00h, `mem_abort` and `row_err` are 0, and every array byte reads FFh.
- R2: Control byte layout: bit 0 write enable, bit 1 busy (read only), bit 2 row mode, bit 3 row start, bit 6 standby. Bits 4, 5 and 7 read as 0, and writes to bits 1, 4, 5 and 7 have no effect.
- R3: An array write while the stored enable bit is 0 leaves the array unchanged and does not raise busy.
- R4: An accepted byte write (enable 1, row mode 0) raises busy in the next cycle. Busy stays high for exactly PROG_CYCLES cycles, and afterwards the byte reads back.
- R5: While busy is 1, `cfg_rdata` reads exactly 02h and control writes are ignored. The stored bits reappear unchanged once busy falls.
- R6: An array access made while busy is dropped and pulses `mem_abort` in the next cycle. `mem_rdata` keeps its previous value, and the operation in progress still completes.
- R7: A 0-to-1 write of the row mode bit empties the row buffer. The first array write after that captures the row from address bits 7..3. Later writes pick a lane with bits 2..0.
- R8: Row start is accepted only when the stored enable and row mode bits are both 1 and the same control write keeps bits 0 and 2 set with standby 0. Otherwise no programming starts and the bit reads 0.
- R9: When a row operation ends, buffered lanes are written to their row and unloaded lanes are written FFh. Row start and row mode both clear, while enable stays set.
- R10: Writing the row mode bit to 0 discards the buffer. A start with an empty buffer still runs a busy period but changes no array byte.
- R11: In row mode, with a row captured, an access to another row pulses `row_err` in the next cycle. Such a write is dropped, and such a read is still served.
- R12: With standby set, array writes do nothing and raise no busy, and reads return 00h.
- R13: An array read that is not aborted places the addressed byte on `mem_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control byte |
| cfg_wdata | input | 8 | Control byte write value |
| cfg_rdata | output | 8 | Control/status byte |
| mem_req | input | 1 | Array access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Array byte address |
| mem_wdata | input | DATA_W | Array write data |
| mem_rdata | output | DATA_W | Registered array read data |
| mem_abort | output | 1 | Pulse: the previous access was dropped because of busy |
| row_err | output | 1 | Pulse: the previous access targeted a row other than the captured one |

## Verification
A buffered row write and the control write that sets row start can arrive in the same clock cycle. The bench provokes this by driving `mem_req`/`mem_we` and `cfg_we` with 0Dh together on one edge. It then judges the outcome by reading back the whole row after busy falls, and the simultaneously written lane must be part of the committed row. A second case feeds accesses and control writes while busy is high and requires that they are dropped without disturbing the byte being programmed.

// File: rtl/ee_ctrl_pkg.sv
package ee_ctrl_pkg;

    // Bit positions inside the control/status byte
    localparam int CR_EN   = 0;
    localparam int CR_BUSY = 1;
    localparam int CR_PEN  = 2;
    localparam int CR_PST  = 3;
    localparam int CR_STBY = 6;

    // What software sees while an operation runs
    localparam logic [7:0] BUSY_VIEW = 8'h02;

    function automatic logic [7:0] pack_status(input logic en, input logic pen,
                                               input logic pst, input logic stby);
        logic [7:0] v;
        v           = '0;
        v[CR_EN]    = en;
        v[CR_PEN]   = pen;
        v[CR_PST]   = pst;
        v[CR_STBY]  = stby;
        return v;
    endfunction

endpackage

// File: rtl/ee_busy_timer.sv
module ee_busy_timer #(
    parameter int unsigned CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d  = t_q;
        done = t_q.busy && (t_q.cnt == '0);
        if (t_q.busy) begin
            if (done) t_d.busy = 1'b0;
            else      t_d.cnt  = t_q.cnt - 1'b1;
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

endmodule

// File: rtl/ee_row_buffer.sv
module ee_row_buffer #(
    parameter int unsigned     DATA_W    = 8,
    parameter int unsigned     ROW_BYTES = 8,
    parameter int unsigned     ROW_W     = 5,
    parameter logic [DATA_W-1:0] FILL    = '1,
    localparam int unsigned    SEL_W     = $clog2(ROW_BYTES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clear,
    input  logic                               wr,
    input  logic [ROW_W-1:0]                   row_in,
    input  logic [SEL_W-1:0]                   sel,
    input  logic [DATA_W-1:0]                  din,
    output logic                               vld,
    output logic [ROW_W-1:0]                   row,
    output logic [ROW_BYTES-1:0]               mask,
    output logic [ROW_BYTES-1:0][DATA_W-1:0]   lanes
);
    typedef struct packed {
        logic                             vld;
        logic [ROW_W-1:0]                 row;
        logic [ROW_BYTES-1:0]             mask;
        logic [ROW_BYTES-1:0][DATA_W-1:0] lat;
    } buf_t;

    buf_t b_q, b_d;

    always_comb begin
        b_d = b_q;
        if (clear) begin
            b_d.vld  = 1'b0;
            b_d.mask = '0;
            b_d.lat  = {ROW_BYTES{FILL}};
        end else if (wr) begin
            if (!b_q.vld) begin
                b_d.vld = 1'b1;
                b_d.row = row_in;
            end
            b_d.mask[sel] = 1'b1;
            b_d.lat[sel]  = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q      <= '0;
            b_q.lat  <= {ROW_BYTES{FILL}};
        end else begin
            b_q <= b_d;
        end
    end

    assign vld   = b_q.vld;
    assign row   = b_q.row;
    assign mask  = b_q.mask;
    assign lanes = b_q.lat;

endmodule

// File: rtl/ee_cell_array.sv
module ee_cell_array #(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter int unsigned       ROW_BYTES = 8,
    parameter logic [DATA_W-1:0] FILL      = '1,
    localparam int unsigned      SEL_W     = $clog2(ROW_BYTES),
    localparam int unsigned      ROW_W     = ADDR_W - SEL_W,
    localparam int unsigned      DEPTH     = 2 ** ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             byte_we,
    input  logic [ADDR_W-1:0]                byte_addr,
    input  logic [DATA_W-1:0]                byte_din,
    input  logic                             row_we,
    input  logic [ROW_W-1:0]                 row_idx,
    input  logic [ROW_BYTES-1:0]             row_mask,
    input  logic [ROW_BYTES-1:0][DATA_W-1:0] row_din,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data
);
    logic [DATA_W-1:0]                 cell_q [DEPTH];
    logic [ROW_BYTES-1:0][DATA_W-1:0]  lane_val;

    // Unloaded lanes of a row commit the fill pattern
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
        assign lane_val[g] = row_mask[g] ? row_din[g] : FILL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= FILL;
        end else if (row_we) begin
            for (int b = 0; b < ROW_BYTES; b++) cell_q[{row_idx, SEL_W'(b)}] <= lane_val[b];
        end else if (byte_we) begin
            cell_q[byte_addr] <= byte_din;
        end
    end

    assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/ee_prog_ctrl.sv
module ee_prog_ctrl
    import ee_ctrl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter int unsigned       ROW_BYTES   = 8,
    parameter int unsigned       PROG_CYCLES = 40000,
    parameter logic [DATA_W-1:0] FILL        = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              mem_abort,
    output logic              row_err
);
    localparam int unsigned SEL_W = $clog2(ROW_BYTES);
    localparam int unsigned ROW_W = ADDR_W - SEL_W;

    typedef struct packed {
        logic              en;
        logic              pen;
        logic              pstart;
        logic              stby;
        logic [ADDR_W-1:0] pend_addr;
        logic [DATA_W-1:0] pend_data;
        logic [DATA_W-1:0] rdata;
        logic              abort;
        logic              row_err;
    } st_t;

    st_t s_q, s_d;

    logic                             busy, prog_done, tmr_start;
    logic                             buf_vld, buf_clr, buf_wr;
    logic [ROW_W-1:0]                 buf_row;
    logic [ROW_BYTES-1:0]             buf_mask;
    logic [ROW_BYTES-1:0][DATA_W-1:0] buf_lanes;
    logic [DATA_W-1:0]                arr_rd;
    logic                             commit_row, commit_byte;
    logic                             acc, cfg_ok, pen_rise, pen_drop;
    logic                             row_hit, row_miss, byte_go, par_go, par_end;
    logic                             en_w, pen_w, pst_w;
    logic                             unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[7], cfg_wdata[5:4], cfg_wdata[CR_BUSY]};

    // Qualify the incoming requests against the registered state
    always_comb begin
        acc      = mem_req && !busy && !s_q.stby;
        cfg_ok   = cfg_we && !busy;
        pen_rise = cfg_ok && cfg_wdata[CR_PEN] && !s_q.pen;
        pen_drop = cfg_ok && !cfg_wdata[CR_PEN] && s_q.pen;
        row_hit  = !buf_vld || (mem_addr[ADDR_W-1:SEL_W] == buf_row);
        row_miss = acc && s_q.pen && !row_hit;
        byte_go  = acc && mem_we && s_q.en && !s_q.pen;
        buf_wr   = acc && mem_we && s_q.en && s_q.pen && row_hit && !pen_drop;
        par_go   = cfg_ok && s_q.en && s_q.pen && cfg_wdata[CR_EN] && cfg_wdata[CR_PEN]
                   && cfg_wdata[CR_PST] && !cfg_wdata[CR_STBY];
        par_end  = prog_done && s_q.pstart;
    end

    assign tmr_start   = byte_go || par_go;
    assign buf_clr     = pen_rise || pen_drop || par_end;
    assign commit_row  = par_end && buf_vld;
    assign commit_byte = prog_done && !s_q.pstart;

    // Next-state computation
    always_comb begin
        s_d         = s_q;
        s_d.abort   = mem_req && busy;
        s_d.row_err = row_miss;

        if (cfg_ok) begin
            s_d.en   = cfg_wdata[CR_EN];
            s_d.pen  = cfg_wdata[CR_PEN];
            s_d.stby = cfg_wdata[CR_STBY];
            if (par_go) s_d.pstart = 1'b1;
        end

        if (par_end) begin
            s_d.pstart = 1'b0;
            s_d.pen    = 1'b0;
        end

        if (byte_go) begin
            s_d.pend_addr = mem_addr;
            s_d.pend_data = mem_wdata;
        end

        if (mem_req && !mem_we && !busy) begin
            s_d.rdata = s_q.stby ? '0 : arr_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ee_busy_timer #(
        .CYCLES (PROG_CYCLES)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (prog_done)
    );

    ee_row_buffer #(
        .DATA_W    (DATA_W),
        .ROW_BYTES (ROW_BYTES),
        .ROW_W     (ROW_W),
        .FILL      (FILL)
    ) i_rowbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (buf_clr),
        .wr     (buf_wr),
        .row_in (mem_addr[ADDR_W-1:SEL_W]),
        .sel    (mem_addr[SEL_W-1:0]),
        .din    (mem_wdata),
        .vld    (buf_vld),
        .row    (buf_row),
        .mask   (buf_mask),
        .lanes  (buf_lanes)
    );

    ee_cell_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ROW_BYTES (ROW_BYTES),
        .FILL      (FILL)
    ) i_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (commit_byte),
        .byte_addr (s_q.pend_addr),
        .byte_din  (s_q.pend_data),
        .row_we    (commit_row),
        .row_idx   (buf_row),
        .row_mask  (buf_mask),
        .row_din   (buf_lanes),
        .rd_addr   (mem_addr),
        .rd_data   (arr_rd)
    );

    assign en_w      = s_q.en;
    assign pen_w     = s_q.pen;
    assign pst_w     = s_q.pstart;
    assign cfg_rdata = busy ? BUSY_VIEW : pack_status(s_q.en, s_q.pen, s_q.pstart, s_q.stby);
    assign mem_rdata = s_q.rdata;
    assign mem_abort = s_q.abort;
    assign row_err   = s_q.row_err;

endmodule

// File: rtl/ee_prog_ctrl_chk.sv
module ee_prog_ctrl_chk #(
    parameter int unsigned PROG_CYCLES = 40000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       mem_req,
    input logic       mem_abort,
    input logic       row_err,
    input logic       busy,
    input logic       en_w,
    input logic       pen_w,
    input logic       pst_w
);
    localparam int CW = $clog2(PROG_CYCLES + 2);
    logic [CW-1:0] blen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    blen_q <= '0;
        else if (busy) blen_q <= blen_q + 1'b1;
        else           blen_q <= '0;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == CW'(PROG_CYCLES)));

    // R3
    no_en_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[1] && !cfg_rdata[0]) |=> !cfg_rdata[1]);

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && busy) |=> mem_abort);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pst_w) |-> $past(en_w && pen_w));

    // R9
    row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pst_w) |-> (!pen_w && !busy));

    // R11
    row_err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_err |-> $past(pen_w));

endmodule

bind ee_prog_ctrl ee_prog_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .mem_req   (mem_req),
    .mem_abort (mem_abort),
    .row_err   (row_err),
    .busy      (busy),
    .en_w      (en_w),
    .pen_w     (pen_w),
    .pst_w     (pst_w)
);

// File: tb/test_ee_prog_ctrl.sv
module test_ee_prog_ctrl;
    localparam int PC = 24;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       mem_req, mem_we;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_abort, row_err;

    always #4 clk = ~clk;

    ee_prog_ctrl #(.PROG_CYCLES(PC)) i_ee_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_abort(mem_abort), .row_err(row_err)
    );

    int         checks = 0;
    int         errors = 0;
    bit         finished = 0;
    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read results and compares
    always @(negedge clk) begin
        logic [7:0] e;
        string      t;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, mem_rdata, e);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_wr(input logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic mem_wr(input logic [7:0] a, input logic [7:0] d);
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        step();
        mem_req = 1'b0; mem_we = 1'b0;
    endtask

    // Driver: issues a read and pushes the expected result
    task automatic mem_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        mem_req = 1'b1; mem_we = 1'b0; mem_addr = a;
        step();
        mem_req = 1'b0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cfg_rdata[1]) begin
            n++;
            step();
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 control after reset", cfg_rdata, 8'h00);
        chk("R1 abort after reset", {7'b0, mem_abort}, 8'h00);
        chk("R1 row_err after reset", {7'b0, row_err}, 8'h00);
        mem_rd(8'h10, 8'hFF, "R1 R13 erased read");

        // R2 layout, R8 start refused without stored enable
        cfg_wr(8'hFF);
        chk("R2 R8 write FFh", cfg_rdata, 8'h45);
        cfg_wr(8'h00);
        chk("R2 write 00h", cfg_rdata, 8'h00);

        // R3 write with enable 0
        mem_wr(8'h20, 8'h5A);
        chk("R3 no busy", cfg_rdata, 8'h00);
        mem_rd(8'h20, 8'hFF, "R3 array unchanged");

        // R4 byte write timing
        cfg_wr(8'h01);
        mem_wr(8'h21, 8'h3C);
        chk("R5 busy view", cfg_rdata, 8'h02);
        wait_idle(n);
        chk("R4 busy length", 8'(n), 8'(PC));
        chk("R5 status after busy", cfg_rdata, 8'h01);
        model[8'h21] = 8'h3C;
        mem_rd(8'h21, 8'h3C, "R4 R13 byte readback");

        // R5 R6 activity during busy
        mem_wr(8'h22, 8'h11);
        cfg_wr(8'h00);
        chk("R5 busy view during write", cfg_rdata, 8'h02);
        mem_wr(8'h23, 8'h99);
        chk("R6 abort on write", {7'b0, mem_abort}, 8'h01);
        mem_rd(8'h21, 8'h3C, "R6 read aborted holds data");
        chk("R6 abort on read", {7'b0, mem_abort}, 8'h01);
        wait_idle(n);
        chk("R5 control write ignored", cfg_rdata, 8'h01);
        model[8'h22] = 8'h11;
        mem_rd(8'h22, 8'h11, "R6 operation completed");
        mem_rd(8'h23, 8'hFF, "R6 aborted write dropped");
        chk("R6 abort clears", {7'b0, mem_abort}, 8'h00);

        // R7 R9 R11 row mode with simultaneous start
        mem_wr(8'h41, 8'h12);
        wait_idle(n);
        cfg_wr(8'h05);
        chk("R7 row mode set", cfg_rdata, 8'h05);
        mem_wr(8'h40, 8'hA0);
        mem_wr(8'h43, 8'hA3);
        mem_wr(8'h47, 8'h77);
        mem_wr(8'h50, 8'hEE);
        chk("R11 row_err on write", {7'b0, row_err}, 8'h01);
        mem_rd(8'h50, 8'hFF, "R11 other-row read served");
        chk("R11 row_err on read", {7'b0, row_err}, 8'h01);
        cfg_we = 1'b1; cfg_wdata = 8'h0D;
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = 8'h45; mem_wdata = 8'h55;
        step();
        cfg_we = 1'b0; mem_req = 1'b0; mem_we = 1'b0;
        chk("R8 start accepted", cfg_rdata, 8'h02);
        wait_idle(n);
        chk("R9 busy length row", 8'(n), 8'(PC));
        chk("R9 flags cleared", cfg_rdata, 8'h01);
        model[8'h40] = 8'hA0; model[8'h41] = 8'hFF; model[8'h43] = 8'hA3;
        model[8'h45] = 8'h55; model[8'h47] = 8'h77;
        for (int a = 8'h40; a < 8'h48; a++) mem_rd(8'(a), model[a], "R9 row readback");
        mem_rd(8'h50, 8'hFF, "R11 other-row write dropped");

        // R10 discard and empty start
        mem_wr(8'h60, 8'h33);
        wait_idle(n);
        model[8'h60] = 8'h33;
        cfg_wr(8'h05);
        mem_wr(8'h61, 8'hC1);
        cfg_wr(8'h01);
        cfg_wr(8'h05);
        cfg_wr(8'h0D);
        chk("R10 empty start busy", cfg_rdata, 8'h02);
        wait_idle(n);
        chk("R10 flags after empty start", cfg_rdata, 8'h01);
        mem_rd(8'h60, 8'h33, "R10 array untouched");
        mem_rd(8'h61, 8'hFF, "R10 buffer discarded");

        // R7 fresh capture after re-enabling row mode
        cfg_wr(8'h05);
        mem_wr(8'h68, 8'h81);
        mem_wr(8'h6A, 8'h82);
        cfg_wr(8'h0D);
        wait_idle(n);
        mem_rd(8'h68, 8'h81, "R7 lane 0");
        mem_rd(8'h69, 8'hFF, "R7 unloaded lane");
        mem_rd(8'h6A, 8'h82, "R7 lane 2");

        // R8 start refused without enable
        cfg_wr(8'h04);
        cfg_wr(8'h0C);
        chk("R8 no start", cfg_rdata, 8'h04);
        cfg_wr(8'h00);

        // R12 standby
        cfg_wr(8'h41);
        chk("R12 standby set", cfg_rdata, 8'h41);
        mem_wr(8'h21, 8'hEE);
        chk("R12 no busy", cfg_rdata, 8'h41);
        mem_rd(8'h21, 8'h00, "R12 standby read");
        cfg_wr(8'h01);
        mem_rd(8'h21, 8'h3C, "R12 write ignored");

        step();
        step();
        finished = 1;
        summary();
        $finish;
    end

endmodule